// File: doc/BRIEF.md
# Peripheral Transfer Controller

This block moves single words between fixed peripheral data registers and system memory on behalf of several channels. Each channel has three software registers. The first is a 32-bit memory pointer. The second is a 16-bit count of transfers still to do. The third is a control word that selects the direction and the step size. When a peripheral raises its trigger line, the channel asks for service. A fixed-priority arbiter picks one channel. A small engine then runs the transfer as two bus phases on a single master port: it reads from the source and then writes to the destination. When the second phase completes, the channel's count drops by one and its pointer moves on by the configured step.

Each channel is bound to its own peripheral register address. This address is computed from a base and a stride, and its index is the channel number. Software still chooses the direction. Each channel drives a completion line back to its peripheral, and this line stays high while the count is zero. The block has no status register of its own.

A rewrite of the count takes effect at once. A transfer that is already on the bus when the count is zeroed still finishes. A clean stop, where the pointer is guaranteed frozen, needs two zero writes to the count in a row.

Top module: `periph_xfer_ctrl`

## Requirements
- R1: After reset every count, pointer and control word is zero, every completion line is high and the bus request is low.
- R2: Register select 0 is the pointer (32 bits), select 1 is the count (the low 16 bits of the write data; it reads back zero-extended), select 2 is the control word (bit 0 is direction, bits 2:1 are the step code, and the other bits read as zero), and select 3 reads zero.
- R3: With direction 0 (receive), a transfer first reads the channel's peripheral address (base + channel × stride) and then writes that data to memory at the pointer.
- R4: With direction 1 (transmit), a transfer first reads memory at the pointer and then writes that data to the channel's peripheral address.
- R5: In the cycle the second phase is acknowledged, the count drops by one and the pointer advances by 1, 2 or 4 bytes for step codes 0, 1 or 2. Step code 3 also advances by 4.
- R6: A channel's completion line is high exactly when its count is zero.
- R7: A trigger that arrives while the channel's count is zero is ignored: no bus request follows and the pointer does not move.
- R8: A count write while the channel is active replaces the count at once, and later transfers count down from the new value.
- R9: When several channels are waiting, the lowest-numbered one is served first, and only one transfer is on the bus at a time.
- R10: A single zero write to the count lets an in-flight transfer finish and move the pointer. After two zero writes to the count in a row, with no nonzero count write between them, the pointer stays frozen even if a transfer then completes. The count stays at zero in both cases.
- R11: Once raised, the bus request, address and write flag hold steady until the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | CW | Channel index for register access |
| reg_sel | input | 2 | Register select: 0 pointer, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| trig | input | NUM_CH | Per-channel peripheral trigger |
| done_o | output | NUM_CH | Per-channel completion (count is zero) |
| bus_req | output | 1 | Bus phase request |
| bus_we | output | 1 | Bus phase is a write |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus phase acknowledge |

## Verification
Some properties are checked on every cycle. These are: the bus request holds steady while a phase is unacknowledged, a fetch is always followed by a write phase, grants are one-hot and lowest-first, a zero count never moves or wakes a channel, and a frozen pointer never changes. Other behaviour only shows in the bench's scenarios. This covers the data actually landing at the right address for each direction and step size, and the order in which two waiting channels are served. It also covers a mid-run count rewrite and the difference between one and two zero writes during a stalled transfer.

// File: rtl/pxc_pkg.sv
`timescale 1ns/1ps
package pxc_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
        dir_e              dir;
        logic [1:0]        size;
    } chan_cfg_t;

    function automatic logic [DATA_W-1:0] step_bytes(input logic [1:0] size);
        logic [DATA_W-1:0] r;
        case (size)
            2'd0:    r = 1;
            2'd1:    r = 2;
            default: r = 4;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] periph_addr(input logic [DATA_W-1:0] base,
                                                      input int stride, input int idx);
        return base + DATA_W'(stride * idx);
    endfunction
endpackage

// File: rtl/pxc_chan.sv
`timescale 1ns/1ps
module pxc_chan
    import pxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_wr,
    input  logic              cnt_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig,
    input  logic              take,
    input  logic              finish,
    output chan_cfg_t         cfg_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              req_o,
    output logic              end_o
);
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] ptr_q;
    dir_e              dir_q;
    logic [1:0]        size_q;
    logic              pend_q;
    logic              zero_seen_q;
    logic              frozen_q;

    logic zero_wr;
    logic freeze_now;
    assign zero_wr    = cnt_wr && (wdata[CNT_W-1:0] == '0);
    assign freeze_now = frozen_q || (zero_wr && zero_seen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            ptr_q       <= '0;
            dir_q       <= DIR_RX;
            size_q      <= '0;
            pend_q      <= 1'b0;
            zero_seen_q <= 1'b0;
            frozen_q    <= 1'b0;
        end else begin
            if (cnt_wr)
                count_q <= wdata[CNT_W-1:0];
            else if (finish && count_q != '0)
                count_q <= count_q - 1'b1;

            if (ptr_wr)
                ptr_q <= wdata;
            else if (finish && !freeze_now)
                ptr_q <= ptr_q + step_bytes(size_q);

            if (ctl_wr) begin
                dir_q  <= dir_e'(wdata[0]);
                size_q <= wdata[2:1];
            end

            if (zero_wr)
                pend_q <= 1'b0;
            else if (trig && count_q != '0)
                pend_q <= 1'b1;
            else if (take || count_q == '0)
                pend_q <= 1'b0;

            if (cnt_wr) begin
                zero_seen_q <= zero_wr;
                frozen_q    <= zero_wr && (frozen_q || zero_seen_q);
            end
        end
    end

    assign cfg_o   = '{ptr: ptr_q, dir: dir_q, size: size_q};
    assign count_o = count_q;
    assign req_o   = pend_q && (count_q != '0);
    assign end_o   = (count_q == '0);

    // R7: an empty channel stays empty and never becomes pending on its own
    p_zero_count_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !cnt_wr) |=> (count_q == '0));
    p_no_wake_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !pend_q) |=> !pend_q);
    // R10: once frozen, the pointer moves only by an explicit write
    p_frozen_ptr_r10: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !ptr_wr) |=> $stable(ptr_q));
endmodule

// File: rtl/pxc_arb.sv
`timescale 1ns/1ps
module pxc_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    assign grant = req & (~req + N'(1));

    // R9: at most one winner, and no lower-numbered requester is skipped
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_grant_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|grant) && (((grant - N'(1)) & req) == '0));
endmodule

// File: rtl/pxc_engine.sv
`timescale 1ns/1ps
module pxc_engine
    import pxc_pkg::*;
#(
    parameter int                N              = 4,
    parameter logic [DATA_W-1:0] PERIPH_BASE    = 32'h8000_0000,
    parameter int                PERIPH_STRIDE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      grant,
    input  chan_cfg_t         cfg [N],
    output logic [N-1:0]      take,
    output logic [N-1:0]      finish,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    eng_state_e        state_q;
    logic [N-1:0]      chan_q;
    logic [DATA_W-1:0] src_q, dst_q, data_q;

    chan_cfg_t         sel_cfg;
    logic [DATA_W-1:0] sel_paddr;

    always_comb begin
        sel_cfg   = '0;
        sel_paddr = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                sel_cfg   = cfg[i];
                sel_paddr = periph_addr(PERIPH_BASE, PERIPH_STRIDE, i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (|grant) begin
                    chan_q <= grant;
                    if (sel_cfg.dir == DIR_RX) begin
                        src_q <= sel_paddr;
                        dst_q <= sel_cfg.ptr;
                    end else begin
                        src_q <= sel_cfg.ptr;
                        dst_q <= sel_paddr;
                    end
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (bus_ack) begin
                    data_q  <= bus_rdata;
                    state_q <= ST_STORE;
                end
                ST_STORE: if (bus_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign take      = (state_q == ST_IDLE) ? grant : '0;
    assign finish    = (state_q == ST_STORE && bus_ack) ? chan_q : '0;
    assign bus_req   = (state_q != ST_IDLE);
    assign bus_we    = (state_q == ST_STORE);
    assign bus_addr  = (state_q == ST_STORE) ? dst_q : src_q;
    assign bus_wdata = data_q;

    // R11: an unacknowledged phase keeps its request, address and direction
    p_hold_phase_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R3: an acknowledged fetch is followed by the write phase
    p_fetch_then_store_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));
    // R9: accepting a channel starts exactly one transfer; completions are single
    p_take_starts_r9: assert property (@(posedge clk) disable iff (rst)
        (|take) |=> (bus_req && !bus_we));
    p_finish_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(finish));
endmodule

// File: rtl/periph_xfer_ctrl.sv
`timescale 1ns/1ps
module periph_xfer_ctrl
    import pxc_pkg::*;
#(
    parameter int          NUM_CH        = 4,
    parameter logic [31:0] PERIPH_BASE   = 32'h8000_0000,
    parameter int          PERIPH_STRIDE = 16,
    localparam int         CW            = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CW-1:0]     reg_chan,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] trig,
    output logic [NUM_CH-1:0] done_o,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    chan_cfg_t        cfg   [NUM_CH];
    logic [CNT_W-1:0] count [NUM_CH];
    logic [NUM_CH-1:0] req, grant, take, finish;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = reg_we && (reg_chan == CW'(i));
        pxc_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .ptr_wr  (hit && reg_sel == SEL_PTR),
            .cnt_wr  (hit && reg_sel == SEL_CNT),
            .ctl_wr  (hit && reg_sel == SEL_CTL),
            .wdata   (reg_wdata),
            .trig    (trig[i]),
            .take    (take[i]),
            .finish  (finish[i]),
            .cfg_o   (cfg[i]),
            .count_o (count[i]),
            .req_o   (req[i]),
            .end_o   (done_o[i])
        );
    end

    pxc_arb #(.N(NUM_CH)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .grant (grant)
    );

    pxc_engine #(
        .N             (NUM_CH),
        .PERIPH_BASE   (PERIPH_BASE),
        .PERIPH_STRIDE (PERIPH_STRIDE)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .cfg       (cfg),
        .take      (take),
        .finish    (finish),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_chan == CW'(i)) begin
                case (reg_sel)
                    SEL_PTR: reg_rdata = cfg[i].ptr;
                    SEL_CNT: reg_rdata = 32'(count[i]);
                    SEL_CTL: reg_rdata = 32'({cfg[i].size, cfg[i].dir});
                    default: reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/tb_periph_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_periph_xfer_ctrl;
    import pxc_pkg::*;

    localparam int          N  = 4;
    localparam logic [31:0] PB = 32'h8000_0000;
    localparam int          PS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_chan = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] trig = '0;
    logic [N-1:0] done_o;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    periph_xfer_ctrl #(.NUM_CH(N), .PERIPH_BASE(PB), .PERIPH_STRIDE(PS)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig), .done_o(done_o),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // memory and peripheral model
    logic [31:0] mem  [64];
    logic [31:0] prx  [N];
    logic [31:0] ptx  [N];
    logic [31:0] wlog [64];
    int          wcnt = 0;
    int          req_cycles = 0;
    logic        stall = 1'b0;

    function automatic int pidx(input logic [31:0] a);
        return int'((a - PB) / PS);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack && !stall) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (bus_addr[31]) ptx[pidx(bus_addr)] <= bus_wdata;
                else              mem[bus_addr[7:2]]  <= bus_wdata;
                if (wcnt < 64) wlog[wcnt] <= bus_addr;
                wcnt <= wcnt + 1;
            end else begin
                bus_rdata <= bus_addr[31] ? prx[pidx(bus_addr)] : mem[bus_addr[7:2]];
            end
        end else begin
            bus_ack <= 1'b0;
        end
        if (bus_req) req_cycles <= req_cycles + 1;
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_chan = 2'(ch); reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input int ch, input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_chan = 2'(ch); reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); trig = m;
        @(negedge clk); trig = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stimulus table: channel, direction, step code, pointer, data
    localparam int NV = 4;
    localparam logic        V_DIR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [1:0]  V_SIZE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
    localparam logic [31:0] V_PTR  [NV] = '{32'h10, 32'h20, 32'h30, 32'h40};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0001, 32'hA5A5_0002, 32'hA5A5_0003, 32'hA5A5_0004};
    localparam logic [31:0] V_INC  [NV] = '{32'd1, 32'd2, 32'd4, 32'd4};

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0, rc;
        for (int i = 0; i < 64; i++) mem[i] <= '0;
        for (int i = 0; i < N; i++) begin prx[i] <= '0; ptx[i] <= '0; end
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rreg(0, SEL_CNT, d); chk("R1 count", d, 32'h0);
        rreg(3, SEL_PTR, d); chk("R1 pointer", d, 32'h0);
        rreg(2, SEL_CTL, d); chk("R1 control", d, 32'h0);
        chk("R1 done lines", 32'(done_o), 32'hF);
        chk("R1 bus idle", 32'(bus_req), 32'h0);

        // R2 register map
        wreg(1, SEL_PTR, 32'h1234_5678);
        rreg(1, SEL_PTR, d); chk("R2 pointer", d, 32'h1234_5678);
        wreg(1, SEL_CNT, 32'h0001_ABCD);
        rreg(1, SEL_CNT, d); chk("R2 count 16 bits", d, 32'h0000_ABCD);
        chk("R6 done low when count nonzero", 32'(done_o[1]), 32'h0);
        wreg(1, SEL_CTL, 32'hFF);
        rreg(1, SEL_CTL, d); chk("R2 control", d, 32'h7);
        rreg(1, SEL_NONE, d); chk("R2 select 3", d, 32'h0);

        // R3 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] dest;
            if (V_DIR[v]) mem[V_PTR[v][7:2]] <= V_DATA[v];
            else          prx[v] <= V_DATA[v];
            wreg(v, SEL_CTL, {29'b0, V_SIZE[v], V_DIR[v]});
            wreg(v, SEL_PTR, V_PTR[v]);
            wreg(v, SEL_CNT, 32'd3);
            w0 = wcnt;
            pulse(N'(1) << v);
            idle(12);
            dest = V_DIR[v] ? (PB + 32'(v * PS)) : V_PTR[v];
            if (V_DIR[v]) chk("R4 peripheral data", ptx[v], V_DATA[v]);
            else          chk("R3 memory data", mem[V_PTR[v][7:2]], V_DATA[v]);
            chk(V_DIR[v] ? "R4 write address" : "R3 write address", wlog[w0], dest);
            rreg(v, SEL_PTR, d); chk("R5 pointer step", d, V_PTR[v] + V_INC[v]);
            rreg(v, SEL_CNT, d); chk("R5 count step", d, 32'd2);
        end

        // R7 trigger with zero count
        wreg(0, SEL_CNT, 32'd0);
        wreg(0, SEL_PTR, 32'h50);
        rc = req_cycles;
        pulse(4'b0001);
        idle(12);
        chk("R7 no bus activity", 32'(req_cycles - rc), 32'h0);
        rreg(0, SEL_PTR, d); chk("R7 pointer unchanged", d, 32'h50);
        chk("R6 done high at zero", 32'(done_o[0]), 32'h1);

        // R6 completion as the last transfer finishes
        wreg(0, SEL_CNT, 32'd1);
        chk("R6 done low", 32'(done_o[0]), 32'h0);
        pulse(4'b0001);
        idle(12);
        chk("R6 done high after last", 32'(done_o[0]), 32'h1);
        rreg(0, SEL_CNT, d); chk("R6 count zero", d, 32'h0);

        // R8 count rewrite mid-run
        wreg(2, SEL_CNT, 32'd5);
        pulse(4'b0100);
        idle(12);
        rreg(2, SEL_CNT, d); chk("R8 first decrement", d, 32'd4);
        wreg(2, SEL_CNT, 32'd10);
        pulse(4'b0100);
        idle(12);
        rreg(2, SEL_CNT, d); chk("R8 counts from new value", d, 32'd9);

        // R9 fixed priority
        wreg(1, SEL_CTL, 32'h0); wreg(1, SEL_PTR, 32'h60); wreg(1, SEL_CNT, 32'd2);
        wreg(2, SEL_CTL, 32'h0); wreg(2, SEL_PTR, 32'h70); wreg(2, SEL_CNT, 32'd2);
        w0 = wcnt;
        pulse(4'b0110);
        idle(20);
        chk("R9 lower channel first", wlog[w0], 32'h60);
        chk("R9 higher channel second", wlog[w0 + 1], 32'h70);

        // R10 single zero write during a stalled transfer, with R11 hold
        wreg(0, SEL_CTL, 32'h4); wreg(0, SEL_PTR, 32'h80); wreg(0, SEL_CNT, 32'd3);
        stall = 1'b1;
        pulse(4'b0001);
        idle(3);
        chk("R3 fetch from peripheral", bus_addr, PB);
        idle(3);
        chk("R11 request held", 32'(bus_req), 32'h1);
        chk("R11 address held", bus_addr, PB);
        wreg(0, SEL_CNT, 32'd0);
        stall = 1'b0;
        idle(12);
        rreg(0, SEL_PTR, d); chk("R10 single zero lets pointer move", d, 32'h84);
        rreg(0, SEL_CNT, d); chk("R10 count stays zero", d, 32'h0);

        // R10 two zero writes freeze the pointer
        wreg(0, SEL_CNT, 32'd3); wreg(0, SEL_PTR, 32'h90);
        stall = 1'b1;
        pulse(4'b0001);
        idle(3);
        wreg(0, SEL_CNT, 32'd0);
        wreg(0, SEL_CNT, 32'd0);
        stall = 1'b0;
        idle(12);
        rreg(0, SEL_PTR, d); chk("R10 pointer frozen", d, 32'h90);
        rreg(0, SEL_CNT, d); chk("R10 count zero after stop", d, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule